// File: doc/BRIEF.md
# Exception Entry Controller

This block holds the processor's exception-state registers and updates them in one clock when an exception is taken. A core raises one or more request lines together with the program counter of the faulting instruction, a flag saying that instruction sits in a branch delay slot, the faulting address and an offset to subtract from the target. The controller picks one request by fixed priority. It records the return address and the cause, and it raises the exception level. For address and translation faults it also captures the faulting address fields. On the next cycle it pulses a redirect strobe with the handler address.

Software reads and writes the seven registers through a small select/data port. Pipeline flush, translation lookup and decode belong to the surrounding core.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status register reads 0x0040_0000 (boot-vector bit 22 set, exception-level bit 1 clear), every other register reads zero, and redirect_o and next_pc_o are zero.
- R2: When an exception is taken with the exception level clear, the return-address register gets pc_i and cause bit 31 (delay flag) is cleared. When in_delay_i is 1, it gets pc_i minus 4 and bit 31 is set instead.
- R3: When an exception is taken with the exception level already set, the return-address register and cause bit 31 keep their values.
- R4: Every taken exception sets status bit 1 and writes cause bits 6:2 with the kind's code. Request lines 0..18 carry codes 0,1,2,3,4,5,8,9,10,11,12,13,18,18,2,3,2,3,24. Cause bits 29:28 and 15:8 are unchanged by entry.
- R5: The vector offset is 0x180 when the exception level was set at entry. Otherwise it is 0x080 for request lines 14 and 15 (64-bit refill, load and store), 0x280 for line 13 (coprocessor-2 trap), and 0x180 for every other line.
- R6: One cycle after a request, redirect_o is 1 for one cycle. next_pc_o equals base plus offset minus base_off_i, in 64-bit wrap-around arithmetic. The base is 0xFFFFFFFFBFC00200 if status bit 22 is set and 0xFFFFFFFF80000000 otherwise. Without a request, redirect_o is 0.
- R7: Request lines 1,2,3,4,5,14,15,16,17 load the bad-address register with bad_addr_i. All other lines leave it unchanged.
- R8: Translation lines 1,2,3,14,15,16,17 also load context bits 22:4 from address bits 31:13. They load extended-context bits 30:4 from address bits 39:13 and bits 32:31 from address bits 63:62. They load entry-high bits 63:62 from address bits 63:62 and bits 39:13 from address bits 39:13. Other bits of these registers are kept.
- R9: When several request lines are high, the lowest-numbered one is taken.
- R10: The software port uses select 0 return address, 1 cause, 2 status, 3 bad address, 4 context, 5 extended context, 6 entry high, and 7 reads zero. Writes are stored through masks. Cause keeps bits 31, 29:28, 15:8 and 6:2. Context and extended context clear bits 3:0. Entry high keeps bits 63:62, 39:13 and 7:0. Status, return address and bad address keep all written bits (status only 31:0).
- R11: A software write in the same cycle as a taken exception is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 19 | Exception request lines, one per kind |
| pc_i | input | 64 | PC of the faulting instruction |
| in_delay_i | input | 1 | Faulting instruction is in a branch delay slot |
| bad_addr_i | input | 64 | Faulting virtual address |
| base_off_i | input | 64 | Offset subtracted from the vector target |
| sw_we_i | input | 1 | Software write enable |
| sw_sel_i | input | 3 | Software register select |
| sw_wdata_i | input | 64 | Software write data |
| sw_rdata_o | output | 64 | Software read data (combinational) |
| redirect_o | output | 1 | One-cycle redirect strobe |
| next_pc_o | output | 64 | Handler address, valid with redirect_o |

## Verification
Corrupted internal state shows at the ports within one cycle of the next exception. A stale exception-level bit moves next_pc_o by the offset difference and wrongly overwrites or preserves the return address. A stale boot-vector bit shifts next_pc_o by the base difference. A wrong delay flag or code shows on the very next cause read. Every kind is swept against both exception levels, both vector bases and both delay-slot states, each from freshly written register markers. Field transfers therefore show up as bit differences against kept marker bits.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN   = 64;
  localparam int CREG_W = 32;
  localparam int EXC_N  = 19;
  localparam int IDX_W  = $clog2(EXC_N);
  localparam int SEL_W  = 3;
  localparam int CODE_W = 5;
  localparam int OFF_W  = 12;

  localparam int ST_BEV = 22;
  localparam int ST_EXL = 1;
  localparam int CA_BD  = 31;

  localparam logic [XLEN-1:0]   VEC_BOOT   = 64'hFFFF_FFFF_BFC0_0200;
  localparam logic [XLEN-1:0]   VEC_NORM   = 64'hFFFF_FFFF_8000_0000;
  localparam logic [CREG_W-1:0] STATUS_RST = CREG_W'(1) << ST_BEV;
  localparam logic [CREG_W-1:0] CAUSE_MASK = 32'hB000_FF7C;
  localparam logic [XLEN-1:0]   CTX_MASK   = 64'hFFFF_FFFF_FFFF_FFF0;
  localparam logic [XLEN-1:0]   EHI_MASK   = 64'hC000_00FF_FFFF_E0FF;

  typedef enum logic [IDX_W-1:0] {
    EX_INT, EX_TLB_MOD, EX_TLB_LD, EX_TLB_ST, EX_ADR_LD, EX_ADR_ST,
    EX_SYSCALL, EX_BREAK, EX_RESV, EX_COP_OFF, EX_OVF, EX_TRAP,
    EX_CP2_EXC, EX_CP2_TRAP, EX_REFILL_LD, EX_REFILL_ST,
    EX_INVAL_LD, EX_INVAL_ST, EX_MCHECK
  } exc_kind_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_EPC, SEL_CAUSE, SEL_STATUS, SEL_BADVA, SEL_CTX, SEL_XCTX, SEL_EHI, SEL_NONE
  } reg_sel_e;

  function automatic logic [CODE_W-1:0] code_of(exc_kind_e k);
    case (k)
      EX_INT:                    return 5'd0;
      EX_TLB_MOD:                return 5'd1;
      EX_TLB_LD, EX_REFILL_LD,
      EX_INVAL_LD:               return 5'd2;
      EX_TLB_ST, EX_REFILL_ST,
      EX_INVAL_ST:               return 5'd3;
      EX_ADR_LD:                 return 5'd4;
      EX_ADR_ST:                 return 5'd5;
      EX_SYSCALL:                return 5'd8;
      EX_BREAK:                  return 5'd9;
      EX_RESV:                   return 5'd10;
      EX_COP_OFF:                return 5'd11;
      EX_OVF:                    return 5'd12;
      EX_TRAP:                   return 5'd13;
      EX_CP2_EXC, EX_CP2_TRAP:   return 5'd18;
      default:                   return 5'd24;
    endcase
  endfunction

  function automatic logic is_tlb(exc_kind_e k);
    return k inside {EX_TLB_MOD, EX_TLB_LD, EX_TLB_ST, EX_REFILL_LD,
                     EX_REFILL_ST, EX_INVAL_LD, EX_INVAL_ST};
  endfunction

  function automatic logic has_addr(exc_kind_e k);
    return is_tlb(k) || k == EX_ADR_LD || k == EX_ADR_ST;
  endfunction
endpackage

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int N = 19,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
  import exc_entry_pkg::*;
(
  input  exc_kind_e       kind_i,
  input  logic            exl_i,
  input  logic            bev_i,
  input  logic [XLEN-1:0] base_off_i,
  output logic [XLEN-1:0] target_o
);
  logic [OFF_W-1:0] off;
  logic [XLEN-1:0]  base;

  always_comb begin
    if (exl_i)                                           off = 12'h180;
    else if (kind_i == EX_REFILL_LD || kind_i == EX_REFILL_ST) off = 12'h080;
    else if (kind_i == EX_CP2_TRAP)                      off = 12'h280;
    else                                                 off = 12'h180;
  end

  assign base     = bev_i ? VEC_BOOT : VEC_NORM;
  assign target_o = base + {{(XLEN-OFF_W){off[OFF_W-1]}}, off} - base_off_i;
endmodule

// File: rtl/exc_cp0_regs.sv
module exc_cp0_regs
  import exc_entry_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  exc_kind_e        kind_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             in_delay_i,
  input  logic [XLEN-1:0]  bad_addr_i,
  input  logic             sw_we_i,
  input  logic [SEL_W-1:0] sw_sel_i,
  input  logic [XLEN-1:0]  sw_wdata_i,
  output logic [XLEN-1:0]  sw_rdata_o,
  output logic             exl_o,
  output logic             bev_o
);
  logic [XLEN-1:0]   epc_q, badva_q, ctx_q, xctx_q, ehi_q;
  logic [CREG_W-1:0] cause_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q    <= '0;
      badva_q  <= '0;
      ctx_q    <= '0;
      xctx_q   <= '0;
      ehi_q    <= '0;
      cause_q  <= '0;
      status_q <= STATUS_RST;
    end else if (take_i) begin
      if (!status_q[ST_EXL]) begin
        epc_q          <= in_delay_i ? pc_i - XLEN'(4) : pc_i;
        cause_q[CA_BD] <= in_delay_i;
      end
      cause_q[6:2]     <= code_of(kind_i);
      status_q[ST_EXL] <= 1'b1;
      if (has_addr(kind_i)) badva_q <= bad_addr_i;
      if (is_tlb(kind_i)) begin
        ctx_q[22:4]   <= bad_addr_i[31:13];
        xctx_q[30:4]  <= bad_addr_i[39:13];
        xctx_q[32:31] <= bad_addr_i[63:62];
        ehi_q[63:62]  <= bad_addr_i[63:62];
        ehi_q[39:13]  <= bad_addr_i[39:13];
      end
    end else if (sw_we_i) begin
      case (reg_sel_e'(sw_sel_i))
        SEL_EPC:    epc_q    <= sw_wdata_i;
        SEL_CAUSE:  cause_q  <= sw_wdata_i[CREG_W-1:0] & CAUSE_MASK;
        SEL_STATUS: status_q <= sw_wdata_i[CREG_W-1:0];
        SEL_BADVA:  badva_q  <= sw_wdata_i;
        SEL_CTX:    ctx_q    <= sw_wdata_i & CTX_MASK;
        SEL_XCTX:   xctx_q   <= sw_wdata_i & CTX_MASK;
        SEL_EHI:    ehi_q    <= sw_wdata_i & EHI_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(sw_sel_i))
      SEL_EPC:    sw_rdata_o = epc_q;
      SEL_CAUSE:  sw_rdata_o = XLEN'(cause_q);
      SEL_STATUS: sw_rdata_o = XLEN'(status_q);
      SEL_BADVA:  sw_rdata_o = badva_q;
      SEL_CTX:    sw_rdata_o = ctx_q;
      SEL_XCTX:   sw_rdata_o = xctx_q;
      SEL_EHI:    sw_rdata_o = ehi_q;
      default:    sw_rdata_o = '0;
    endcase
  end

  assign exl_o = status_q[ST_EXL];
  assign bev_o = status_q[ST_BEV];

  AST_EXL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> status_q[ST_EXL]); // R4
  AST_EPC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !status_q[ST_EXL] |=> epc_q == $past(pc_i) - (cause_q[CA_BD] ? XLEN'(4) : XLEN'(0))); // R2
  AST_EPC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && status_q[ST_EXL] |=> $stable(epc_q) && $stable(cause_q[CA_BD])); // R3
  AST_BADVA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !has_addr(kind_i) |=> $stable(badva_q)); // R7
  AST_CTX_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && is_tlb(kind_i) |=> ctx_q[22:4] == badva_q[31:13] && ehi_q[39:13] == xctx_q[30:4]); // R8
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXC_N-1:0] exc_req_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             in_delay_i,
  input  logic [XLEN-1:0]  bad_addr_i,
  input  logic [XLEN-1:0]  base_off_i,
  input  logic             sw_we_i,
  input  logic [SEL_W-1:0] sw_sel_i,
  input  logic [XLEN-1:0]  sw_wdata_i,
  output logic [XLEN-1:0]  sw_rdata_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  next_pc_o
);
  logic             take;
  logic [IDX_W-1:0] idx;
  exc_kind_e        kind;
  logic             exl, bev;
  logic [XLEN-1:0]  target;

  exc_prio_enc #(.N(EXC_N)) u_prio (
    .req_i  (exc_req_i),
    .valid_o(take),
    .idx_o  (idx)
  );
  assign kind = exc_kind_e'(idx);

  exc_vec_calc u_vec (
    .kind_i    (kind),
    .exl_i     (exl),
    .bev_i     (bev),
    .base_off_i(base_off_i),
    .target_o  (target)
  );

  exc_cp0_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .kind_i    (kind),
    .pc_i      (pc_i),
    .in_delay_i(in_delay_i),
    .bad_addr_i(bad_addr_i),
    .sw_we_i   (sw_we_i),
    .sw_sel_i  (sw_sel_i),
    .sw_wdata_i(sw_wdata_i),
    .sw_rdata_o(sw_rdata_o),
    .exl_o     (exl),
    .bev_o     (bev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      next_pc_o  <= '0;
    end else begin
      redirect_o <= take;
      if (take) next_pc_o <= target;
    end
  end

  AST_REDIRECT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> redirect_o); // R6
  AST_NO_STRAY_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> !redirect_o); // R6
  AST_GRANT_IS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> exc_req_i[idx] && (exc_req_i & ((EXC_N'(1) << idx) - EXC_N'(1))) == '0); // R9
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] exc_req = '0;
  logic [63:0] pc = '0, bad_addr = '0, base_off = '0, sw_wdata = '0;
  logic        in_delay = 1'b0, sw_we = 1'b0;
  logic [2:0]  sw_sel = '0;
  logic [63:0] sw_rdata, next_pc;
  logic        redirect;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .pc_i(pc),
    .in_delay_i(in_delay), .bad_addr_i(bad_addr), .base_off_i(base_off),
    .sw_we_i(sw_we), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
    .sw_rdata_o(sw_rdata), .redirect_o(redirect), .next_pc_o(next_pc)
  );

  localparam logic [63:0] EPC_MARK = 64'h1111_2222_3333_4444;
  localparam logic [63:0] BVA_MARK = 64'h5555_6666_7777_8888;
  localparam logic [63:0] ONES     = '1;

  function automatic logic [4:0] exp_code(int k);
    case (k)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;  4: return 4;
      5: return 5;  6: return 8;  7: return 9;  8: return 10; 9: return 11;
      10: return 12; 11: return 13; 12: return 18; 13: return 18;
      14: return 2; 15: return 3; 16: return 2; 17: return 3; default: return 24;
    endcase
  endfunction
  function automatic logic tlb_kind(int k);
    return k inside {1, 2, 3, 14, 15, 16, 17};
  endfunction
  function automatic logic addr_kind(int k);
    return tlb_kind(k) || k == 4 || k == 5;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic sw_write(int sel, logic [63:0] d);
    sw_we = 1'b1; sw_sel = 3'(sel); sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic rd(int sel, output logic [63:0] v);
    sw_sel = 3'(sel);
    #1;
    v = sw_rdata;
  endtask

  task automatic raise(logic [18:0] req);
    exc_req = req;
    @(negedge clk);
    exc_req = '0;
  endtask

  logic [63:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "redirect", 64'(redirect), 64'd0);
    check("R1", "next_pc", next_pc, 64'd0);
    for (int s = 0; s < 8; s++) begin
      rd(s, v);
      check("R1", $sformatf("reg%0d", s), v, s == 2 ? 64'h0040_0000 : 64'd0);
    end

    // R10 masks and select 7
    @(negedge clk);
    sw_write(1, ONES);
    sw_write(4, ONES);
    sw_write(6, ONES);
    sw_write(7, ONES);
    rd(1, v); check("R10", "cause mask", v, 64'hB000_FF7C);
    rd(4, v); check("R10", "ctx mask", v, 64'hFFFF_FFFF_FFFF_FFF0);
    rd(6, v); check("R10", "ehi mask", v, 64'hC000_00FF_FFFF_E0FF);
    rd(7, v); check("R10", "sel7", v, 64'd0);

    // full sweep: kind x exl x bev x delay
    for (int k = 0; k < 19; k++) begin
      for (int m = 0; m < 8; m++) begin
        logic exl, bev, dly;
        logic [63:0] e_epc, e_cause, e_bva, e_ctx, e_xctx, e_ehi, e_pc;
        logic [11:0] off;
        exl = m[0]; bev = m[1]; dly = m[2];
        @(negedge clk);
        sw_write(2, 64'((bev ? 32'h0040_0000 : 32'h0) | (exl ? 32'h2 : 32'h0) | 32'h1));
        sw_write(0, EPC_MARK);
        sw_write(1, ONES);
        sw_write(3, BVA_MARK);
        sw_write(4, ONES);
        sw_write(5, ONES);
        sw_write(6, ONES);
        pc       = 64'hFFFF_FFFF_8000_1000 + 64'(k * 8);
        bad_addr = 64'hC3A5_00AB_CDEF_1234 ^ (64'(k) << 20) ^ (64'(m) << 61);
        base_off = 64'(k) * 64'h100 + 64'(m);
        in_delay = dly;
        raise(19'(1) << k);
        check("R6", "redirect high", 64'(redirect), 64'd1);
        off = exl ? 12'h180 : (k == 14 || k == 15) ? 12'h080 : (k == 13) ? 12'h280 : 12'h180;
        e_pc = (bev ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000) + 64'(off) - base_off;
        check(exl ? "R5" : "R6", "next_pc", next_pc, e_pc);
        e_epc = exl ? EPC_MARK : (dly ? pc - 64'd4 : pc);
        rd(0, v); check(exl ? "R3" : "R2", "epc", v, e_epc);
        e_cause = 64'h3000_FF00 | (64'(exp_code(k)) << 2) | ((exl | dly) ? 64'h8000_0000 : 64'd0);
        rd(1, v); check("R4", "cause", v, e_cause);
        rd(2, v); check("R4", "status", v, (bev ? 64'h0040_0000 : 64'd0) | 64'h3);
        e_bva = addr_kind(k) ? bad_addr : BVA_MARK;
        rd(3, v); check("R7", "badva", v, e_bva);
        e_ctx = 64'hFFFF_FFFF_FFFF_FFF0;
        e_xctx = 64'hFFFF_FFFF_FFFF_FFF0;
        e_ehi = 64'hC000_00FF_FFFF_E0FF;
        if (tlb_kind(k)) begin
          e_ctx[22:4]   = bad_addr[31:13];
          e_xctx[30:4]  = bad_addr[39:13];
          e_xctx[32:31] = bad_addr[63:62];
          e_ehi[63:62]  = bad_addr[63:62];
          e_ehi[39:13]  = bad_addr[39:13];
        end
        rd(4, v); check("R8", "ctx", v, e_ctx);
        rd(5, v); check("R8", "xctx", v, e_xctx);
        rd(6, v); check("R8", "ehi", v, e_ehi);
        @(negedge clk);
        check("R6", "redirect low", 64'(redirect), 64'd0);
      end
    end

    // R9 priority
    in_delay = 1'b0;
    sw_write(2, 64'd0);
    raise(19'h40088);
    rd(1, v); check("R9", "code lines 3,7,18", 64'(v[6:2]), 64'd3);
    sw_write(2, 64'd0);
    raise('1);
    rd(1, v); check("R9", "code all lines", 64'(v[6:2]), 64'd0);
    check("R9", "next_pc all lines", next_pc, 64'hFFFF_FFFF_8000_0180 - base_off);

    // R11 collision: write dropped
    sw_write(2, 64'd0);
    pc = 64'h0000_0000_0040_2000;
    exc_req = 19'(1) << 6;
    sw_we = 1'b1; sw_sel = 3'd0; sw_wdata = EPC_MARK;
    @(negedge clk);
    exc_req = '0; sw_we = 1'b0;
    rd(0, v); check("R11", "epc on collision", v, pc);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule